// File: doc/BRIEF.md
# Dual-line page-program command receiver

This block sits on the device side of a serial flash port and decodes one command: a page program whose data phase uses two data lines. While chip select is low it takes an 8-bit opcode and a 24-bit address on one line, one bit per serial clock. It then collects data bytes two bits per serial clock into a page buffer of 256 bytes. The low address byte gives the starting position and the upper address bits select the page. A write that runs past the last position of the page continues at position zero of the same page.

When chip select rises exactly after a whole data byte, the block issues a one-cycle program request. The request carries the page base address, the buffer contents and a mask that marks every byte position written in the transaction. A program engine downstream consumes the request. All serial inputs are sampled on a fast system clock and are assumed to be already synchronous to it. Edges of the serial clock and of chip select are found by comparing each input with its value one system clock earlier.

Top module: `dpp_rx`

## Requirements
- R1: After reset, prog_req_o is low, prog_mask_o is all zeros and prog_addr_o is zero.
- R2: The opcode and then the address are shifted in on dq0_i, most significant bit first, one bit per rising edge of sclk_i. After a valid command, prog_addr_o equals the received address with bits 7..0 forced to zero.
- R3: Each data byte takes four rising edges of sclk_i and is sent most significant pair first. In each pair dq1_i is the higher bit and dq0_i the lower bit. Byte k of the data phase lands at page position (A7..A0 + k) mod 256, visible in prog_data_o bits [8p+7:8p] for position p.
- R4: Data that runs past position 255 wraps to position 0 of the same page. The page base is unchanged by the wrap.
- R5: When more than 256 bytes are sent, later bytes overwrite earlier ones, so the buffer holds the last 256 bytes received and the mask is all ones.
- R6: Bit p of prog_mask_o is set only if a complete data byte was written to position p in the current transaction. The mask does not change while chip select stays high.
- R7: A program request is issued only when chip select rises after a whole number of data bytes, at least one. A rise in the middle of a byte, during the address or before any data byte gives no request.
- R8: If the opcode differs from parameter OPCODE (default 8'hA2), the rest of the transaction is ignored. No byte is written, the mask stays zero and no request is issued.
- R9: prog_req_o is a pulse of exactly one clk_i cycle. It is asserted in the cycle after the rising edge of cs_ni is sampled.
- R10: The mask is cleared when the falling edge of cs_ni is sampled, so it starts each transaction empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample all serial inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data sampled on its rising edge |
| cs_ni | input | 1 | Active-low chip select framing a transaction |
| dq0_i | input | 1 | Serial line 0: opcode, address and the low bit of each data pair |
| dq1_i | input | 1 | Serial line 1: the high bit of each data pair |
| prog_req_o | output | 1 | One-cycle program request |
| prog_addr_o | output | 24 | Page base address of the request |
| prog_data_o | output | 2048 | Page buffer, position p in bits [8p+7:8p] |
| prog_mask_o | output | 256 | Written-byte mask, bit p for position p |

## Verification
The assertions assume that chip select and the serial clock never change in the same system clock cycle. They also assume that each input holds for several system clocks, so that every edge is seen exactly once. The bench drives all lines on the falling edge of clk_i and holds each serial clock phase for three system clocks. It changes data lines only while the serial clock is low, and it moves chip select only while the serial clock is low. Within those rules the stimulus covers a wrong opcode, an address cut short, a transaction with no data, a cut inside a byte, a wrap at the top of the page and an overrun of the page size.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } dpp_state_e;
endpackage

// File: rtl/dpp_edge.sv
// Edge finder for inputs already synchronous to clk_i.
module dpp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  output logic sclk_rise_o,
  output logic cs_fall_o,
  output logic cs_rise_o
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  assign sclk_rise_o = sclk_i & ~sclk_q;
  assign cs_fall_o   = ~cs_ni & cs_q;
  assign cs_rise_o   = cs_ni & ~cs_q;
endmodule

// File: rtl/dpp_ctrl.sv
module dpp_ctrl
  import dpp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned OPC_W      = 8,
  parameter logic [7:0]  OPCODE     = 8'hA2,
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              cs_ni,
  input  logic              dq0_i,
  input  logic              dq1_i,
  output logic              wr_en_o,
  output logic [OFF_W-1:0]  wr_idx_o,
  output logic [7:0]        wr_byte_o,
  output logic              clr_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam int unsigned PAIRS  = 8 / LANES;
  localparam int unsigned PAIR_W = $clog2(PAIRS);
  localparam int unsigned CNT_W  = $clog2(ADDR_W);
  localparam int unsigned DSR_W  = (PAIRS - 1) * LANES;
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;
  localparam logic [CNT_W-1:0]  OPC_LAST  = CNT_W'(OPC_W - 1);
  localparam logic [CNT_W-1:0]  ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [PAIR_W-1:0] PAIR_LAST = PAIR_W'(PAIRS - 1);

  dpp_state_e        st_q;
  logic [ADDR_W-1:0] sr_q, sr_next;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAIR_W-1:0] pair_q;
  logic [DSR_W-1:0]  dsr_q;
  logic [OFF_W-1:0]  ptr_q;
  logic [PAGE_W-1:0] page_q;
  logic              got_q, req_q, bit_ev;

  assign bit_ev  = sclk_rise_i & ~cs_ni & ~cs_fall_i;
  assign sr_next = {sr_q[ADDR_W-2:0], dq0_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sr_q   <= '0;
      cnt_q  <= '0;
      pair_q <= '0;
      dsr_q  <= '0;
      ptr_q  <= '0;
      page_q <= '0;
      got_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (cs_fall_i) begin
        st_q   <= ST_OPC;
        cnt_q  <= '0;
        pair_q <= '0;
        got_q  <= 1'b0;
      end else if (cs_rise_i) begin
        // complete bytes only, at least one
        req_q <= (st_q == ST_DATA) && (pair_q == '0) && got_q;
        st_q  <= ST_IDLE;
      end else if (bit_ev) begin
        unique case (st_q)
          ST_OPC: begin
            sr_q  <= sr_next;
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == OPC_LAST) begin
              cnt_q <= '0;
              st_q  <= (sr_next[OPC_W-1:0] == OPCODE) ? ST_ADDR : ST_SKIP;
            end
          end
          ST_ADDR: begin
            sr_q  <= sr_next;
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == ADDR_LAST) begin
              page_q <= sr_next[ADDR_W-1:OFF_W];
              ptr_q  <= sr_next[OFF_W-1:0];
              st_q   <= ST_DATA;
            end
          end
          ST_DATA: begin
            dsr_q  <= {dsr_q[DSR_W-LANES-1:0], dq1_i, dq0_i};
            pair_q <= pair_q + PAIR_W'(1);
            if (pair_q == PAIR_LAST) begin
              ptr_q <= ptr_q + OFF_W'(1);  // wraps inside the page
              got_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en_o   = bit_ev && (st_q == ST_DATA) && (pair_q == PAIR_LAST);
  assign wr_idx_o  = ptr_q;
  assign wr_byte_o = {dsr_q, dq1_i, dq0_i};
  assign clr_o     = cs_fall_i;
  assign req_o     = req_q;
  assign base_o    = {page_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/dpp_page_buf.sv
module dpp_page_buf #(
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    wr_en_i,
  input  logic [OFF_W-1:0]        wr_idx_i,
  input  logic [7:0]              wr_byte_i,
  output logic [PAGE_BYTES*8-1:0] data_o,
  output logic [PAGE_BYTES-1:0]   mask_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[8*g +: 8] <= '0;
        mask_o[g]        <= 1'b0;
      end else if (clr_i) begin
        mask_o[g] <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == OFF_W'(g))) begin
        data_o[8*g +: 8] <= wr_byte_i;
        mask_o[g]        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpp_rx.sv
module dpp_rx #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned OPC_W      = 8,
  parameter logic [7:0]  OPCODE     = 8'hA2,
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sclk_i,
  input  logic                    cs_ni,
  input  logic                    dq0_i,
  input  logic                    dq1_i,
  output logic                    prog_req_o,
  output logic [ADDR_W-1:0]       prog_addr_o,
  output logic [PAGE_BYTES*8-1:0] prog_data_o,
  output logic [PAGE_BYTES-1:0]   prog_mask_o
);
  logic             sclk_rise, cs_fall, cs_rise, wr_en, clr;
  logic [OFF_W-1:0] wr_idx;
  logic [7:0]       wr_byte;

  dpp_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .cs_ni       (cs_ni),
    .sclk_rise_o (sclk_rise),
    .cs_fall_o   (cs_fall),
    .cs_rise_o   (cs_rise)
  );

  dpp_ctrl #(
    .ADDR_W     (ADDR_W),
    .OPC_W      (OPC_W),
    .OPCODE     (OPCODE),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_rise_i (sclk_rise),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .cs_ni       (cs_ni),
    .dq0_i       (dq0_i),
    .dq1_i       (dq1_i),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_byte_o   (wr_byte),
    .clr_o       (clr),
    .req_o       (prog_req_o),
    .base_o      (prog_addr_o)
  );

  dpp_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_byte_i (wr_byte),
    .data_o    (prog_data_o),
    .mask_o    (prog_mask_o)
  );
endmodule

// File: rtl/dpp_rx_chk.sv
module dpp_rx_chk #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cs_ni,
  input logic                  prog_req_o,
  input logic [ADDR_W-1:0]     prog_addr_o,
  input logic [PAGE_BYTES-1:0] prog_mask_o
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |=> !prog_req_o); // R9

  AST_REQ_AFTER_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> ($past(cs_ni) && !$past(cs_ni, 2))); // R7

  AST_REQ_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> (prog_mask_o != '0)); // R7

  AST_BASE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> (prog_addr_o[OFF_W-1:0] == '0)); // R2

  AST_MASK_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_ni) |=> (prog_mask_o == '0)); // R10

  AST_MASK_HELD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> $stable(prog_mask_o)); // R6
endmodule

bind dpp_rx dpp_rx_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .prog_req_o  (prog_req_o),
  .prog_addr_o (prog_addr_o),
  .prog_mask_o (prog_mask_o)
);

// File: tb/sim_dpp_rx.sv
module sim_dpp_rx;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned HALF       = 3;
  localparam logic [7:0]  OPC        = 8'hA2;
  localparam int unsigned NVEC       = 8;

  // {opcode[8], addr[24], addr_bits[5], nbytes[10], extra_pairs[3]}
  localparam logic [49:0] VEC [NVEC] = '{
    {8'hA2, 24'h123400, 5'd24, 10'd4,   3'd0}, // R2 R3 R6 basic
    {8'hA2, 24'h0A55FE, 5'd24, 10'd5,   3'd0}, // R4 wrap
    {8'hA2, 24'h7F0010, 5'd24, 10'd300, 3'd0}, // R5 overrun
    {8'hA2, 24'h000080, 5'd24, 10'd3,   3'd2}, // R7 mid-byte cut
    {8'h5A, 24'h111111, 5'd24, 10'd4,   3'd0}, // R8 wrong opcode, R10 clear
    {8'hA2, 24'h222222, 5'd10, 10'd0,   3'd0}, // R7 cut in address
    {8'hA2, 24'h3300FF, 5'd24, 10'd0,   3'd0}, // R7 no data byte
    {8'hA2, 24'hFFFFFF, 5'd24, 10'd1,   3'd0}  // R3 last position
  };

  logic clk = 1'b0, rst_ni = 1'b0, sclk = 1'b0, cs_n = 1'b1, dq0 = 1'b0, dq1 = 1'b0;
  logic         prog_req;
  logic [23:0]  prog_addr;
  logic [2047:0] prog_data;
  logic [255:0] prog_mask;

  int checks = 0, errors = 0, req_cycles = 0;
  logic [23:0] cap_addr;
  logic [7:0]  exp_buf [256];
  logic [255:0] exp_mask;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dpp_rx u0 (
    .clk_i (clk), .rst_ni (rst_ni), .sclk_i (sclk), .cs_ni (cs_n),
    .dq0_i (dq0), .dq1_i (dq1), .prog_req_o (prog_req),
    .prog_addr_o (prog_addr), .prog_data_o (prog_data), .prog_mask_o (prog_mask)
  );

  always @(negedge clk) begin
    if (prog_req) begin
      req_cycles <= req_cycles + 1;
      cap_addr   <= prog_addr;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b1, input logic b0);
    dq1 = b1;
    dq0 = b0;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int k, input int v);
    return 8'((k * 29) + (v * 71) + 3);
  endfunction

  task automatic run_vec(input int v);
    logic [49:0] e;
    logic [7:0]  opc, off, b;
    logic [23:0] addr;
    int abits, nb, extra;
    bit exp_req;
    int bad, bad_p;
    e = VEC[v];
    {opc, addr} = e[49:18];
    abits = int'(e[17:13]);
    nb    = int'(e[12:3]);
    extra = int'(e[2:0]);
    off   = addr[7:0];
    exp_req  = (opc == OPC) && (abits == 24) && (nb > 0) && (extra == 0);
    exp_mask = '0;
    req_cycles = 0;

    wait_clk(1);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 7; i >= 0; i--) pulse(1'b0, opc[i]);
    for (int i = 0; i < abits; i++) pulse(1'b0, addr[23 - i]);
    if (abits == 24) begin
      for (int k = 0; k < nb; k++) begin
        b = pat(k, v);
        for (int j = 0; j < 4; j++) pulse(b[7 - 2*j], b[6 - 2*j]);
        if (opc == OPC) begin
          exp_buf[8'(off + 8'(k))]  = b;
          exp_mask[8'(off + 8'(k))] = 1'b1;
        end
      end
      for (int x = 0; x < extra; x++) pulse(1'b1, 1'b1);
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(6);

    if (exp_req) begin
      check(req_cycles == 1, "R9", $sformatf("v%0d request cycles", v), 64'(req_cycles), 64'd1);
      check(cap_addr == {addr[23:8], 8'h00}, "R2", $sformatf("v%0d page base", v),
            64'(cap_addr), 64'({addr[23:8], 8'h00}));
      bad = 0;
      bad_p = 0;
      for (int p = 0; p < 256; p++) begin
        if (exp_mask[p] && (prog_data[8*p +: 8] != exp_buf[p])) begin
          if (bad == 0) bad_p = p;
          bad++;
        end
      end
      check(bad == 0, (v == 1) ? "R4" : (v == 2) ? "R5" : "R3",
            $sformatf("v%0d data at pos %0d", v, bad_p),
            64'(prog_data[8*bad_p +: 8]), 64'(exp_buf[bad_p]));
    end else begin
      check(req_cycles == 0, (opc != OPC) ? "R8" : "R7",
            $sformatf("v%0d unexpected request", v), 64'(req_cycles), 64'd0);
    end
    check(prog_mask == exp_mask, (v == 4) ? "R10" : (v == 2) ? "R5" : "R6",
          $sformatf("v%0d mask popcount", v),
          64'($countones(prog_mask)), 64'($countones(exp_mask)));
    if (v == 2)
      check(&prog_mask, "R5", "overrun mask all ones", 64'($countones(prog_mask)), 64'd256);
    if (v == 4)
      check(prog_mask == '0, "R8", "ignored opcode mask zero",
            64'($countones(prog_mask)), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 256; p++) exp_buf[p] = 8'h00;
    wait_clk(3);
    check(prog_req == 1'b0, "R1", "reset req", 64'(prog_req), 64'd0);
    check(prog_mask == '0, "R1", "reset mask", 64'($countones(prog_mask)), 64'd0);
    check(prog_addr == '0, "R1", "reset addr", 64'(prog_addr), 64'd0);
    rst_ni = 1'b1;
    wait_clk(3);
    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R1: reset mid-transaction returns to the idle state
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 7; i >= 0; i--) pulse(1'b0, OPC[i]);
    rst_ni = 1'b0;
    wait_clk(2);
    check(prog_mask == '0, "R1", "mask after mid reset", 64'($countones(prog_mask)), 64'd0);
    check(prog_addr == '0, "R1", "addr after mid reset", 64'(prog_addr), 64'd0);
    cs_n = 1'b1;
    wait_clk(2);
    rst_ni = 1'b1;
    wait_clk(4);
    check(prog_req == 1'b0, "R1", "req after mid reset", 64'(prog_req), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule